// File: doc/BRIEF.md
# Oversampled Serial Receiver with Character Queue

This block turns an asynchronous serial line into a queue of received characters. The line is sampled on a clock enable that pulses 16 times per bit period. A start bit is confirmed at its centre. Data bits are then taken at the centres of the following bit cells, least significant bit first, followed by an optional parity bit and the first stop bit. Each finished character is written into a 16-entry queue. Every entry stores the data byte together with its own parity, framing and break flags.

The surrounding logic supplies the character format (length, stop count, parity mode) and the queue mode controls. It pops the queue with a read strobe and acknowledges line status with a status-read strobe. The block reports when data is present, when a character was lost, the error flags of the head entry, whether any stored entry is in error, when the fill level has reached a programmable threshold, and when a partly filled queue has gone quiet. With queueing switched off, the block acts as a single holding register.

Top module: `uart_rx_core`

## Requirements
- R1: `wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. A start bit is accepted only if the line is still low on the 8th tick after the falling edge. Data bits are sampled every 16 ticks after that point, least significant bit first. Unused high bits of `rd_data` read as 0.
- R2: When `par_en`=1, the expected parity bit is set by the mode. Odd mode (`par_even`=0, `par_stick`=0) expects the parity bit that makes the total number of ones odd. Even mode (`par_even`=1, `par_stick`=0) expects the bit that makes it even. `par_stick`=1 with `par_even`=0 expects 1, and `par_stick`=1 with `par_even`=1 expects 0. A mismatch sets that entry's parity flag.
- R3: Only the first stop bit is checked, whatever `stop2` says. A low stop sample sets the entry's framing flag. After a framing error on a character that held a one, the low stop sample is taken as the centre of a new start bit, and data bits follow 16 ticks later.
- R4: If the start bit, all data bits, any parity bit and the stop bit are all sampled low, exactly one entry with data 0 and the break and framing flags set is stored. No further character is taken until the line has returned high.
- R5: The queue holds 16 entries, oldest first. `data_ready` is 1 while at least one entry is held. `rd_en` pops the head entry. A read with the queue empty leaves the queue unchanged, and `rd_data` then shows the last byte that was popped.
- R6: With queueing on, a character that completes while all 16 entries are held is discarded and `overrun` is set at once. `overrun` stays set until a `status_rd` pulse.
- R7: `head_pe`, `head_fe` and `head_bi` show the flags of the head entry only, and read 0 when the queue is empty.
- R8: `fifo_err` is set when an entry with any error flag is stored while queueing is on. A `status_rd` pulse clears it only if no stored entry still carries an error.
- R9: `trig_sel` values 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 entries. `trig_hit` is 1 while queueing is on and the fill level is at or above the selected threshold.
- R10: With queueing on and at least one entry held, `timeout` goes to 1 once four character times pass with no character stored and no `rd_en`. A character time is counted in ticks from the format: start, data, parity and stop bits, with 1.5 stop bits for 5-bit characters when `stop2`=1. Each stored character or `rd_en` restarts the count.
- R11: A one-cycle `fifo_clr` empties the queue but does not disturb a character being shifted in. That character is stored when it completes.
- R12: With `fifo_en`=0 the queue holds at most one character. A new character overwrites an unread one and sets `overrun`. `trig_hit`, `timeout` and `fifo_err` stay 0 in this mode. Any change of `fifo_en` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Serial line, idle high |
| wlen | input | 2 | Data bit count code |
| stop2 | input | 1 | Long stop setting (affects character time only) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even / forced-zero select |
| par_stick | input | 1 | Forced parity select |
| fifo_en | input | 1 | Queue mode on |
| fifo_clr | input | 1 | Queue flush pulse |
| trig_sel | input | 2 | Fill threshold code |
| rd_en | input | 1 | Pop head entry |
| status_rd | input | 1 | Status acknowledge pulse |
| rd_data | output | 8 | Head data byte, or last popped byte when empty |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Character lost |
| head_pe | output | 1 | Head entry parity flag |
| head_fe | output | 1 | Head entry framing flag |
| head_bi | output | 1 | Head entry break flag |
| fifo_err | output | 1 | Some stored entry carries an error |
| trig_hit | output | 1 | Fill level at or above threshold |
| timeout | output | 1 | Quiet queue indication |

## Verification
The bench sweeps all four character lengths and all four parity modes with correct and corrupted parity bits. A receiver that sampled off-centre, shifted MSB first or applied parity the wrong way round would return wrong bytes or wrong parity flags. At every fill level from 0 to 16 it checks all four thresholds, then overfills by one: a wrong full test would store the 17th byte or miss the overrun. It sends a low stop bit followed at once by the next data bits, to catch receivers that do not resynchronise, and holds the line low for two character times, to catch a break logged more than once. The remaining checks cover a head-only error view that leaks later flags, an any-error flag cleared too early, a quiet-queue timer that ignores reads, a flush that loses the character being shifted in, and a single-register mode that keeps the old byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic       bi;
      logic       fe;
      logic       pe;
      logic [7:0] data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_START,
      RS_DATA,
      RS_PAR,
      RS_STOP,
      RS_BRK
   } rx_state_t;

   // Character length in half bit times: start, data, parity, stop part.
   function automatic logic [4:0] frame_half_bits(input logic [1:0] wl,
                                                  input logic       pen,
                                                  input logic       st2);
      logic [4:0] body;
      logic [4:0] tail;
      body = 5'd2 * (5'd6 + {3'd0, wl} + {4'd0, pen});
      if (!st2)           tail = 5'd2;
      else if (wl == 2'd0) tail = 5'd3;
      else                tail = 5'd4;
      return body + tail;
   endfunction

   function automatic logic entry_has_err(input rx_entry_t e);
      return e.pe | e.fe | e.bi;
   endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx,
   input  logic [1:0] wlen,
   input  logic      par_en,
   input  logic      par_even,
   input  logic      par_stick,
   output logic      ch_vld,
   output rx_entry_t ch_ent
);
   localparam int CW   = $clog2(OSR);
   localparam int HALF = OSR / 2;

   rx_state_t  st;
   logic [CW-1:0] cnt;
   logic [2:0] bidx;
   logic [7:0] shf;
   logic       anyone;
   logic       parbit;

   logic [2:0] last_idx;
   logic       cell_end;
   logic       exp_par;
   logic       brk;

   assign last_idx = 3'd4 + {1'b0, wlen};
   assign cell_end = (cnt == CW'(OSR - 1));
   assign exp_par  = par_stick ? ~par_even : (par_even ? ^shf : ~(^shf));
   assign brk      = !rx && !anyone;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RS_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shf    <= '0;
         anyone <= 1'b0;
         parbit <= 1'b0;
         ch_vld <= 1'b0;
         ch_ent <= '0;
      end else begin
         ch_vld <= 1'b0;
         if (tick) begin
            unique case (st)
               RS_IDLE: begin
                  if (!rx) begin
                     st  <= RS_START;
                     cnt <= CW'(1);
                  end
               end
               RS_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     if (!rx) begin
                        st     <= RS_DATA;
                        cnt    <= '0;
                        bidx   <= '0;
                        shf    <= '0;
                        anyone <= 1'b0;
                     end else begin
                        st <= RS_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RS_DATA: begin
                  if (cell_end) begin
                     cnt       <= '0;
                     shf[bidx] <= rx;
                     anyone    <= anyone | rx;
                     if (bidx == last_idx) st <= par_en ? RS_PAR : RS_STOP;
                     else                  bidx <= bidx + 3'd1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RS_PAR: begin
                  if (cell_end) begin
                     cnt    <= '0;
                     parbit <= rx;
                     anyone <= anyone | rx;
                     st     <= RS_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RS_STOP: begin
                  if (cell_end) begin
                     cnt         <= '0;
                     ch_vld      <= 1'b1;
                     ch_ent.data <= shf;
                     ch_ent.pe   <= par_en && !brk && (parbit != exp_par);
                     ch_ent.fe   <= !rx;
                     ch_ent.bi   <= brk;
                     if (rx) begin
                        st <= RS_IDLE;
                     end else if (brk) begin
                        st <= RS_BRK;
                     end else begin
                        // low stop sample counts as centre of a new start bit
                        st     <= RS_DATA;
                        bidx   <= '0;
                        shf    <= '0;
                        anyone <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RS_BRK: begin
                  if (rx) st <= RS_IDLE;
               end
               default: st <= RS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       single,
   input  logic                       push,
   input  rx_entry_t                  push_ent,
   input  logic                       pop,
   output rx_entry_t                  head,
   output logic [$clog2(DEPTH):0]     count,
   output logic [$clog2(DEPTH):0]     err_cnt,
   output logic                       push_acc,
   output logic                       ovr_evt
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   rx_entry_t     mem [DEPTH];
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;

   logic has, pop_ok, full, ovw, wr_new, err_new, err_head;

   assign has      = (count != '0);
   assign pop_ok   = pop && has;
   assign full     = single ? has : (count == CW'(DEPTH));
   assign ovr_evt  = push && !clr && full && !pop_ok;
   assign ovw      = ovr_evt && single;
   assign wr_new   = push && !clr && (!full || pop_ok);
   assign push_acc = wr_new || ovw;
   assign head     = mem[rp];
   assign err_new  = entry_has_err(push_ent);
   assign err_head = entry_has_err(head);

   always_ff @(posedge clk) begin
      if (wr_new)    mem[wp] <= push_ent;
      else if (ovw)  mem[rp] <= push_ent;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         count   <= '0;
         err_cnt <= '0;
      end else if (clr) begin
         wp      <= '0;
         rp      <= '0;
         count   <= '0;
         err_cnt <= '0;
      end else begin
         if (wr_new) wp <= wp + PW'(1);
         if (pop_ok) rp <= rp + PW'(1);
         count   <= count + CW'(wr_new) - CW'(pop_ok);
         err_cnt <= err_cnt + CW'(push_acc && err_new)
                            - CW'((pop_ok || ovw) && err_head);
      end
   end
endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo #(
   parameter int OSR   = 16,
   parameter int TMR_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [4:0] half_bits,
   output logic       expired
);
   logic [TMR_W-1:0] cnt;
   logic [TMR_W-1:0] limit;

   // four character times = half_bits * (OSR/2) * 4 ticks
   assign limit = TMR_W'(half_bits) * TMR_W'(2 * OSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (restart) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (tick && !expired) begin
         if (cnt >= limit - TMR_W'(1)) expired <= 1'b1;
         else                          cnt     <= cnt + TMR_W'(1);
      end
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMR_W       = 12,
   parameter int TRIG0       = 1,
   parameter int TRIG1       = 4,
   parameter int TRIG2       = 8,
   parameter int TRIG3       = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rx_in,
   input  logic [1:0] wlen,
   input  logic       stop2,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       par_stick,
   input  logic       fifo_en,
   input  logic       fifo_clr,
   input  logic [1:0] trig_sel,
   input  logic       rd_en,
   input  logic       status_rd,
   output logic [7:0] rd_data,
   output logic       data_ready,
   output logic       overrun,
   output logic       head_pe,
   output logic       head_fe,
   output logic       head_bi,
   output logic       fifo_err,
   output logic       trig_hit,
   output logic       timeout
);
   localparam int CW = $clog2(DEPTH) + 1;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TRIG3 > DEPTH || TRIG0 < 1) begin : g_bad_trig
      $error("trigger thresholds must lie within the queue depth");
   end
   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 4");
   end
   if (24 * 2 * OSR >= (1 << TMR_W)) begin : g_bad_tmr
      $error("TMR_W too narrow for four character times");
   end

   // line synchroniser
   logic rx_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_in;
   end else begin : g_sync
      logic [SYNC_STAGES:0] chain;
      assign chain[0] = rx_in;
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g+1] <= 1'b1;
            else        chain[g+1] <= chain[g];
         end
      end
      assign rx_s = chain[SYNC_STAGES];
   end

   logic      ch_vld;
   rx_entry_t ch_ent;

   uart_rx_deser #(.OSR(OSR)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .rx       (rx_s),
      .wlen     (wlen),
      .par_en   (par_en),
      .par_even (par_even),
      .par_stick(par_stick),
      .ch_vld   (ch_vld),
      .ch_ent   (ch_ent)
   );

   logic          fifo_en_q;
   logic          mode_chg;
   logic          q_clr;
   rx_entry_t     head;
   logic [CW-1:0] count;
   logic [CW-1:0] err_cnt;
   logic          push_acc;
   logic          ovr_evt;
   logic          has;

   assign mode_chg = fifo_en ^ fifo_en_q;
   assign q_clr    = fifo_clr | mode_chg;
   assign has      = (count != '0);

   uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (q_clr),
      .single  (!fifo_en),
      .push    (ch_vld),
      .push_ent(ch_ent),
      .pop     (rd_en),
      .head    (head),
      .count   (count),
      .err_cnt (err_cnt),
      .push_acc(push_acc),
      .ovr_evt (ovr_evt)
   );

   logic expired;

   uart_rx_tmo #(.OSR(OSR), .TMR_W(TMR_W)) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .restart  (push_acc | rd_en | !has | !fifo_en | q_clr),
      .half_bits(frame_half_bits(wlen, par_en, stop2)),
      .expired  (expired)
   );

   logic [7:0] last_q;
   logic       ovr_q;
   logic       err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en_q <= 1'b0;
         last_q    <= '0;
         ovr_q     <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         fifo_en_q <= fifo_en;
         if (rd_en && has) last_q <= head.data;
         if (ovr_evt)        ovr_q <= 1'b1;
         else if (status_rd) ovr_q <= 1'b0;
         if (push_acc && fifo_en && !q_clr && entry_has_err(ch_ent)) err_q <= 1'b1;
         else if (q_clr || (status_rd && err_cnt == '0))              err_q <= 1'b0;
      end
   end

   logic [CW-1:0] thr;
   always_comb begin
      unique case (trig_sel)
         2'd0:    thr = CW'(TRIG0);
         2'd1:    thr = CW'(TRIG1);
         2'd2:    thr = CW'(TRIG2);
         default: thr = CW'(TRIG3);
      endcase
   end

   assign rd_data    = has ? head.data : last_q;
   assign data_ready = has;
   assign overrun    = ovr_q;
   assign head_pe    = has & head.pe;
   assign head_fe    = has & head.fe;
   assign head_bi    = has & head.bi;
   assign fifo_err   = err_q;
   assign trig_hit   = fifo_en && (count >= thr);
   assign timeout    = fifo_en && has && expired;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
   input logic clk,
   input logic rst_n,
   input logic fifo_clr,
   input logic fifo_en,
   input logic rd_en,
   input logic status_rd,
   input logic data_ready,
   input logic overrun,
   input logic trig_hit,
   input logic timeout
);
   p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> !data_ready);

   p_mode_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fifo_en) || $fell(fifo_en)) |=> !data_ready);

   p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !status_rd) |=> overrun);

   p_trig_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit |-> data_ready);

   p_tmo_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !timeout);
endmodule

bind uart_rx_core uart_rx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_clr  (fifo_clr),
   .fifo_en   (fifo_en),
   .rd_en     (rd_en),
   .status_rd (status_rd),
   .data_ready(data_ready),
   .overrun   (overrun),
   .trig_hit  (trig_hit),
   .timeout   (timeout)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx_in = 1'b1;
   logic [1:0] wlen = 2'd3;
   logic       stop2 = 1'b0;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic       par_stick = 1'b0;
   logic       fifo_en = 1'b1;
   logic       fifo_clr = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       rd_en = 1'b0;
   logic       status_rd = 1'b0;
   logic [7:0] rd_data;
   logic       data_ready, overrun, head_pe, head_fe, head_bi;
   logic       fifo_err, trig_hit, timeout;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   uart_rx_core u_uart_rx_core (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
      .wlen(wlen), .stop2(stop2), .par_en(par_en), .par_even(par_even),
      .par_stick(par_stick), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
      .trig_sel(trig_sel), .rd_en(rd_en), .status_rd(status_rd),
      .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
      .head_pe(head_pe), .head_fe(head_fe), .head_bi(head_bi),
      .fifo_err(fifo_err), .trig_hit(trig_hit), .timeout(timeout)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic line(input logic v);
      rx_in = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nb, input logic pen,
                       input logic pb, input logic stopv);
      line(1'b0);
      for (int i = 0; i < nb; i++) line(d[i]);
      if (pen) line(pb);
      line(stopv);
      rx_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(output logic [7:0] d, output logic pe, output logic fe, output logic bi);
      d  = rd_data;
      pe = head_pe;
      fe = head_fe;
      bi = head_bi;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic stat();
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic exp_par(input logic [7:0] d, input logic ev, input logic sk);
      if (sk) return ~ev;
      return ev ? ^d : ~(^d);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic pe, fe, bi;
      logic [7:0] vals [6];
      int thr [4];
      vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};
      thr  = '{1, 4, 8, 14};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 reset data_ready", data_ready, 0);
      check("R6 reset overrun", overrun, 0);
      check("R5 reset rd_data", rd_data, 0);
      check("R10 reset timeout", timeout, 0);
      check("R8 reset fifo_err", fifo_err, 0);

      // R1: all lengths, several patterns
      for (int w = 0; w < 4; w++) begin
         wlen = 2'(w);
         for (int k = 0; k < 6; k++) begin
            send(vals[k], 5 + w, 1'b0, 1'b0, 1'b1);
            rd(d, pe, fe, bi);
            check("R1 data by length", d, vals[k] & 8'((1 << (5 + w)) - 1));
         end
      end
      check("R1 queue drained", data_ready, 0);
      wlen = 2'd3;

      // R2: parity modes, good and bad parity bits
      par_en = 1'b1;
      for (int m = 0; m < 4; m++) begin
         par_even  = m[0];
         par_stick = m[1];
         for (int k = 0; k < 2; k++) begin
            d = (k == 0) ? 8'h5B : 8'h00;
            send(d, 8, 1'b1, exp_par(d, par_even, par_stick), 1'b1);
            send(d, 8, 1'b1, ~exp_par(d, par_even, par_stick), 1'b1);
         end
         for (int k = 0; k < 4; k++) begin
            rd(d, pe, fe, bi);
            check("R2 parity flag", pe, k % 2);
            check("R2 no framing flag", fe, 0);
         end
      end
      par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;
      stat();

      // R3: low stop then immediate next data bits; stop2 ignored by receiver
      stop2 = 1'b1;
      line(1'b0);
      for (int i = 0; i < 8; i++) line(8'h81 >> i);
      line(1'b0);
      for (int i = 0; i < 8; i++) line(8'h3C >> i);
      line(1'b1);
      send(8'h11, 8, 1'b0, 1'b0, 1'b1);
      send(8'h22, 8, 1'b0, 1'b0, 1'b1);
      rd(d, pe, fe, bi);
      check("R3 first data", d, 8'h81);
      check("R3 framing flag set", fe, 1);
      check("R3 not break", bi, 0);
      rd(d, pe, fe, bi);
      check("R3 resync data", d, 8'h3C);
      check("R3 resync clean", fe, 0);
      rd(d, pe, fe, bi);
      check("R3 one stop accepted", {fe, d}, {1'b0, 8'h11});
      rd(d, pe, fe, bi);
      check("R3 one stop accepted 2", {fe, d}, {1'b0, 8'h22});
      stop2 = 1'b0;
      stat();

      // R4: long low line gives exactly one break entry
      rx_in = 1'b0;
      repeat (400) @(negedge clk);
      rx_in = 1'b1;
      repeat (40) @(negedge clk);
      rd(d, pe, fe, bi);
      check("R4 break data zero", d, 0);
      check("R4 break flag", bi, 1);
      check("R4 break framing flag", fe, 1);
      check("R4 single break entry", data_ready, 0);
      send(8'h47, 8, 1'b0, 1'b0, 1'b1);
      rd(d, pe, fe, bi);
      check("R4 reception resumes", {bi, d}, {1'b0, 8'h47});
      stat();

      // R9 thresholds at every fill level, R5 order, R6 overrun
      for (int k = 0; k <= 16; k++) begin
         if (k > 0) send(8'(8'h10 + k), 8, 1'b0, 1'b0, 1'b1);
         for (int t = 0; t < 4; t++) begin
            trig_sel = 2'(t);
            @(negedge clk);
            check("R9 threshold", trig_hit, (k >= thr[t]) ? 1 : 0);
         end
      end
      check("R6 no overrun when just full", overrun, 0);
      send(8'hEE, 8, 1'b0, 1'b0, 1'b1);
      check("R6 overrun on 17th", overrun, 1);
      for (int k = 1; k <= 16; k++) begin
         rd(d, pe, fe, bi);
         check("R5 order", d, 8'(8'h10 + k));
      end
      check("R6 17th not stored", data_ready, 0);
      check("R6 overrun held", overrun, 1);
      stat();
      check("R6 overrun cleared", overrun, 0);
      rd(d, pe, fe, bi);
      check("R5 empty read last value", d, 8'h20);
      check("R5 empty read keeps empty", data_ready, 0);
      trig_sel = 2'd0;

      // R7 / R8 head flags and any-error flag
      par_en = 1'b1;
      send(8'h12, 8, 1'b1, exp_par(8'h12, 1'b0, 1'b0), 1'b1);
      send(8'h34, 8, 1'b1, ~exp_par(8'h34, 1'b0, 1'b0), 1'b1);
      send(8'h56, 8, 1'b1, exp_par(8'h56, 1'b0, 1'b0), 1'b1);
      check("R7 head clean", head_pe, 0);
      check("R8 error stored", fifo_err, 1);
      rd(d, pe, fe, bi);
      check("R7 head now bad", head_pe, 1);
      stat();
      check("R8 stays while error held", fifo_err, 1);
      rd(d, pe, fe, bi);
      check("R7 next head clean", head_pe, 0);
      stat();
      check("R8 cleared", fifo_err, 0);
      rd(d, pe, fe, bi);
      par_en = 1'b0;

      // R10 quiet timer, 4 x 160 ticks
      send(8'h99, 8, 1'b0, 1'b0, 1'b1);
      repeat (500) @(negedge clk);
      check("R10 not yet", timeout, 0);
      repeat (200) @(negedge clk);
      check("R10 expired", timeout, 1);
      rd(d, pe, fe, bi);
      check("R10 empty no timeout", timeout, 0);
      send(8'h01, 8, 1'b0, 1'b0, 1'b1);
      send(8'h02, 8, 1'b0, 1'b0, 1'b1);
      repeat (500) @(negedge clk);
      rd(d, pe, fe, bi);
      repeat (500) @(negedge clk);
      check("R10 read restarts", timeout, 0);
      repeat (200) @(negedge clk);
      check("R10 expired after read", timeout, 1);
      rd(d, pe, fe, bi);

      // R11 flush during reception
      send(8'h0A, 8, 1'b0, 1'b0, 1'b1);
      send(8'h0B, 8, 1'b0, 1'b0, 1'b1);
      fork
         send(8'h77, 8, 1'b0, 1'b0, 1'b1);
         begin
            repeat (80) @(negedge clk);
            fifo_clr = 1'b1;
            @(negedge clk);
            fifo_clr = 1'b0;
         end
      join
      rd(d, pe, fe, bi);
      check("R11 in-flight char kept", d, 8'h77);
      check("R11 old entries gone", data_ready, 0);

      // R12 single holding register
      fifo_en = 1'b0;
      repeat (3) @(negedge clk);
      send(8'h61, 8, 1'b0, 1'b0, 1'b1);
      check("R12 holds one", data_ready, 1);
      send(8'h62, 8, 1'b0, 1'b0, 1'b1);
      check("R12 overrun", overrun, 1);
      check("R12 overwritten", rd_data, 8'h62);
      check("R12 no threshold", trig_hit, 0);
      repeat (700) @(negedge clk);
      check("R12 no timeout", timeout, 0);
      rd(d, pe, fe, bi);
      check("R12 single entry", data_ready, 0);
      stat();
      par_en = 1'b1;
      send(8'h33, 8, 1'b1, ~exp_par(8'h33, 1'b0, 1'b0), 1'b1);
      check("R12 no any-error", fifo_err, 0);
      check("R12 head parity", head_pe, 1);
      par_en = 1'b0;
      fifo_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 mode change empties", data_ready, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule